// File: doc/BRIEF.md
# Linked Command List Walker

This block is a bus master that steps through a chain of command blocks kept in a 16-bit word memory. Each block holds a status word, a command word and a 32-bit pointer to the next block. A start pulse carries the address of the first block. For each block the walker does four things in turn:

- It stamps the block as busy.
- It reads the command word.
- It hands the 3-bit opcode and the block address to an external executor through a valid/done handshake.
- It stamps the block as complete and reads the two halves of the next pointer.

Three flag bits in the command word decide what happens after a block. One stops the walk, one parks the unit in a suspended state, and one raises an interrupt. The walk also stops when the next pointer is all zeros or all ones. The walker reports its unit state as idle, suspended or active. It keeps a command-complete status bit that reflects the interrupt flag of the last finished block. The work of each opcode is done by the executor, not by this block.

Top module: `cmdlist_walker`

## Requirements
- R1: After reset the unit state is idle (code 0), and `mem_req_o`, `exec_valid_o`, `irq_o` and `cmd_cx_o` are all low. The state codes are 0 idle, 1 suspended and 2 active, and code 3 never appears.
- R2: A `start_i` pulse while the unit is idle or suspended sets the state to active (2) in the next cycle. It also loads `head_i` as the first block address, and the first memory access is a write of 0x4000 to that address.
- R3: Each block at byte address A is processed in this fixed order: write 0x4000 to A, read the command word at A+2, run the execute handshake, write 0xA000 to A, read the low pointer half at A+4, then read the high pointer half at A+6.
- R4: `exec_valid_o` stays high with `exec_op_o` equal to command bits [2:0] and `exec_blk_o` equal to A until `exec_done_i` is sampled high. All eight opcodes 0 to 7 are passed through.
- R5: `mem_req_o` holds its address, write enable and write data stable until `mem_ack_i` is sampled high, for any number of wait cycles.
- R6: A next pointer of 0x00000000 or 0xFFFFFFFF ends the walk after the current block, and the state returns to idle.
- R7: Command bit 15 ends the walk after the current block, whatever the pointer value. The pointer is still read, and the state returns to idle.
- R8: Command bit 14 ends the walk after the current block and leaves the state at suspended (1). A later start resumes from the new head.
- R9: When a block finishes, command bit 13 sets `cmd_cx_o` and gives a one-cycle pulse on `irq_o`. If bit 13 is clear, `cmd_cx_o` is cleared and no pulse is given.
- R10: A `start_i` pulse while the state is active is ignored, and the access stream of the current walk is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle start pulse |
| head_i | input | 32 | Byte address of the first block, sampled with `start_i` |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Byte address of the 16-bit word |
| mem_wdata_o | output | 16 | Write data |
| mem_ack_i | input | 1 | Memory acknowledge, one cycle |
| mem_rdata_i | input | 16 | Read data, valid with `mem_ack_i` |
| exec_valid_o | output | 1 | Executor request for the current block |
| exec_op_o | output | 3 | Opcode of the current block |
| exec_blk_o | output | 32 | Address of the current block |
| exec_done_i | input | 1 | Executor finished, one cycle |
| unit_state_o | output | 2 | 0 idle, 1 suspended, 2 active |
| irq_o | output | 1 | Interrupt pulse for a flagged block |
| cmd_cx_o | output | 1 | Command-complete status bit |

## Verification
The bench builds the walker with its default 16-bit word, which gives 32-bit pointers. With that width the all-ones terminator is 0xFFFFFFFF, and the bench drives it next to the zero terminator. The bench memory answers with an acknowledge delay of zero to four cycles, and the executor answers with a delay of zero to two cycles. This exercises both the held-request path and the back-to-back path. Chains of eight blocks cover every opcode, and a second start is pulsed partway through one walk. A walk that suspends is resumed from a new head.

// File: rtl/cmdlist_pkg.sv
// Package: types shared by the command list walker.
// Assumes: a single clock domain; the word width is a multiple of 8.
package cmdlist_pkg;

    // Unit state as reported on the port; codes are fixed by R1.
    typedef enum logic [1:0] {
        UNIT_IDLE   = 2'd0,
        UNIT_SUSP   = 2'd1,
        UNIT_ACTIVE = 2'd2
    } unit_state_e;

    // Per-block phase of the walk.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_MARK,
        PH_FETCH,
        PH_EXEC,
        PH_CLOSE,
        PH_LINK_LO,
        PH_LINK_HI,
        PH_DECIDE
    } phase_e;

endpackage

// File: rtl/cmdlist_mem_port.sv
// Module: word-memory request/acknowledge driver.
// What it does: latches one access when issue_i pulses and holds it on the bus
// until mem_ack_i. One cycle after the acknowledge it gives a done pulse with the
// read data captured.
// Assumes: issue_i is pulsed only while no access is outstanding.
module cmdlist_mem_port #(
    parameter int WORD_W = 16,
    parameter int PTR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic              we_i,
    input  logic [PTR_W-1:0]  addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic              done_o,
    output logic [WORD_W-1:0] rdata_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [PTR_W-1:0]  mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [WORD_W-1:0] mem_rdata_i
);

    logic              req_q;
    logic              we_q;
    logic [PTR_W-1:0]  addr_q;
    logic [WORD_W-1:0] wdata_q;
    logic              done_q;
    logic [WORD_W-1:0] rdata_q;

    // Hold the request from issue until acknowledge; report completion a cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (issue_i) begin
                req_q   <= 1'b1;
                we_q    <= we_i;
                addr_q  <= addr_i;
                wdata_q <= wdata_i;
            end else if (req_q && mem_ack_i) begin
                req_q   <= 1'b0;
                done_q  <= 1'b1;
                rdata_q <= mem_rdata_i;
            end
        end
    end

    assign mem_req_o   = req_q;
    assign mem_we_o    = we_q;
    assign mem_addr_o  = addr_q;
    assign mem_wdata_o = wdata_q;
    assign done_o      = done_q;
    assign rdata_o     = rdata_q;

endmodule

// File: rtl/cmdlist_cmd_decode.sv
// Module: command word field splitter.
// What it does: separates the opcode and the three control flags (stop,
// suspend, interrupt) held in the top three bits of a command word.
// Assumes: WORD_W > OP_W + 3; the bits between them are reserved.
module cmdlist_cmd_decode #(
    parameter int WORD_W = 16,
    parameter int OP_W   = 3
) (
    input  logic [WORD_W-1:0] word_i,
    output logic [OP_W-1:0]   op_o,
    output logic              last_o,
    output logic              susp_o,
    output logic              intr_o
);

    localparam int LAST_POS = WORD_W - 1;
    localparam int SUSP_POS = WORD_W - 2;
    localparam int INTR_POS = WORD_W - 3;

    logic unused_reserved;

    // Pure field extraction; reserved bits are reduced away.
    always_comb begin
        op_o   = word_i[OP_W-1:0];
        last_o = word_i[LAST_POS];
        susp_o = word_i[SUSP_POS];
        intr_o = word_i[INTR_POS];
    end

    assign unused_reserved = ^word_i[INTR_POS-1:OP_W];

endmodule

// File: rtl/cmdlist_link_reg.sv
// Module: next-pointer assembler.
// What it does: collects a pointer from two word halves (low first, then high)
// and flags the two end-of-list values, all zeros and all ones.
// Assumes: sel_i = 0 picks the low half and sel_i = 1 the high half.
module cmdlist_link_reg #(
    parameter int WORD_W = 16,
    parameter int PTR_W  = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic              sel_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [PTR_W-1:0]  ptr_o,
    output logic              end_o
);

    localparam int HALVES = PTR_W / WORD_W;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        logic [WORD_W-1:0] half_q;

        // Capture this half when its slot is selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                half_q <= '0;
            end else if (cap_i && (sel_i == 1'(h))) begin
                half_q <= word_i;
            end
        end

        assign ptr_o[h*WORD_W +: WORD_W] = half_q;
    end

    // Either terminator value ends the walk.
    assign end_o = (ptr_o == '0) || (ptr_o == '1);

endmodule

// File: rtl/cmdlist_seq.sv
// Module: walk sequencer.
// What it does: runs the per-block phases (mark busy, fetch, execute, close,
// read the link) and decides after each block whether to stop, suspend or go on.
// Assumes: mem_done_i pulses once for each issue_o, one cycle or more later.
module cmdlist_seq #(
    parameter int WORD_W = 16,
    parameter int PTR_W  = 2 * WORD_W,
    parameter int OP_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PTR_W-1:0]  head_i,
    output logic              issue_o,
    output logic              we_o,
    output logic [PTR_W-1:0]  addr_o,
    output logic [WORD_W-1:0] wdata_o,
    input  logic              mem_done_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic              last_i,
    input  logic              susp_i,
    input  logic              intr_i,
    output logic              cap_o,
    output logic              cap_sel_o,
    input  logic [PTR_W-1:0]  link_i,
    input  logic              link_end_i,
    output logic              exec_valid_o,
    output logic [OP_W-1:0]   exec_op_o,
    output logic [PTR_W-1:0]  exec_blk_o,
    input  logic              exec_done_i,
    output logic [1:0]        state_o,
    output logic              irq_o,
    output logic              cx_o
);

    import cmdlist_pkg::*;

    localparam int                WB        = WORD_W / 8;
    localparam logic [PTR_W-1:0]  OFF_CMD   = PTR_W'(WB);
    localparam logic [PTR_W-1:0]  OFF_LO    = PTR_W'(2 * WB);
    localparam logic [PTR_W-1:0]  OFF_HI    = PTR_W'(3 * WB);
    localparam logic [WORD_W-1:0] BUSY_WORD = WORD_W'(1) << (WORD_W - 2);
    localparam logic [WORD_W-1:0] DONE_WORD = (WORD_W'(1) << (WORD_W - 1))
                                            | (WORD_W'(1) << (WORD_W - 3));

    phase_e           phase_q;
    unit_state_e      state_q;
    logic             wait_q;
    logic [PTR_W-1:0] blk_q;
    logic [OP_W-1:0]  op_q;
    logic             last_q;
    logic             susp_q;
    logic             intr_q;
    logic             irq_q;
    logic             cx_q;
    logic             mem_phase;

    // Select the access that belongs to the current phase.
    always_comb begin
        mem_phase = 1'b0;
        we_o      = 1'b0;
        addr_o    = blk_q;
        wdata_o   = '0;
        unique case (phase_q)
            PH_MARK: begin
                mem_phase = 1'b1;
                we_o      = 1'b1;
                wdata_o   = BUSY_WORD;
            end
            PH_FETCH: begin
                mem_phase = 1'b1;
                addr_o    = blk_q + OFF_CMD;
            end
            PH_CLOSE: begin
                mem_phase = 1'b1;
                we_o      = 1'b1;
                wdata_o   = DONE_WORD;
            end
            PH_LINK_LO: begin
                mem_phase = 1'b1;
                addr_o    = blk_q + OFF_LO;
            end
            PH_LINK_HI: begin
                mem_phase = 1'b1;
                addr_o    = blk_q + OFF_HI;
            end
            default: ;
        endcase
    end

    // Issue once per memory phase; route link words to the assembler.
    always_comb begin
        issue_o   = mem_phase && !wait_q;
        cap_o     = mem_done_i && ((phase_q == PH_LINK_LO) || (phase_q == PH_LINK_HI));
        cap_sel_o = (phase_q == PH_LINK_HI);
    end

    // Phase progression, flag capture and the after-block decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            state_q <= UNIT_IDLE;
            wait_q  <= 1'b0;
            blk_q   <= '0;
            op_q    <= '0;
            last_q  <= 1'b0;
            susp_q  <= 1'b0;
            intr_q  <= 1'b0;
            irq_q   <= 1'b0;
            cx_q    <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        blk_q   <= head_i;
                        state_q <= UNIT_ACTIVE;
                        phase_q <= PH_MARK;
                    end
                end
                PH_EXEC: begin
                    if (exec_done_i) begin
                        phase_q <= PH_CLOSE;
                    end
                end
                PH_DECIDE: begin
                    cx_q  <= intr_q;
                    irq_q <= intr_q;
                    if (susp_q) begin
                        state_q <= UNIT_SUSP;
                        phase_q <= PH_IDLE;
                    end else if (last_q || link_end_i) begin
                        state_q <= UNIT_IDLE;
                        phase_q <= PH_IDLE;
                    end else begin
                        blk_q   <= link_i;
                        phase_q <= PH_MARK;
                    end
                end
                default: begin
                    if (issue_o) begin
                        wait_q <= 1'b1;
                    end else if (mem_done_i) begin
                        wait_q <= 1'b0;
                        unique case (phase_q)
                            PH_MARK:    phase_q <= PH_FETCH;
                            PH_FETCH: begin
                                op_q    <= op_i;
                                last_q  <= last_i;
                                susp_q  <= susp_i;
                                intr_q  <= intr_i;
                                phase_q <= PH_EXEC;
                            end
                            PH_CLOSE:   phase_q <= PH_LINK_LO;
                            PH_LINK_LO: phase_q <= PH_LINK_HI;
                            default:    phase_q <= PH_DECIDE;
                        endcase
                    end
                end
            endcase
        end
    end

    assign exec_valid_o = (phase_q == PH_EXEC);
    assign exec_op_o    = op_q;
    assign exec_blk_o   = blk_q;
    assign state_o      = state_q;
    assign irq_o        = irq_q;
    assign cx_o         = cx_q;

endmodule

// File: rtl/cmdlist_walker.sv
// Module: top of the linked command list walker.
// What it does: joins the sequencer, the memory port, the command decoder and
// the pointer assembler into one bus-master unit.
// Assumes: a single clock, synchronous active-low reset, and pointers of two words.
module cmdlist_walker #(
    parameter int WORD_W = 16,
    parameter int OP_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [2*WORD_W-1:0] head_i,
    output logic                mem_req_o,
    output logic                mem_we_o,
    output logic [2*WORD_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0]   mem_wdata_o,
    input  logic                mem_ack_i,
    input  logic [WORD_W-1:0]   mem_rdata_i,
    output logic                exec_valid_o,
    output logic [OP_W-1:0]     exec_op_o,
    output logic [2*WORD_W-1:0] exec_blk_o,
    input  logic                exec_done_i,
    output logic [1:0]          unit_state_o,
    output logic                irq_o,
    output logic                cmd_cx_o
);

    localparam int PTR_W = 2 * WORD_W;

    logic              issue;
    logic              acc_we;
    logic [PTR_W-1:0]  acc_addr;
    logic [WORD_W-1:0] acc_wdata;
    logic              acc_done;
    logic [WORD_W-1:0] acc_rdata;
    logic [OP_W-1:0]   dec_op;
    logic              dec_last;
    logic              dec_susp;
    logic              dec_intr;
    logic              link_cap;
    logic              link_sel;
    logic [PTR_W-1:0]  link_ptr;
    logic              link_end;

    cmdlist_seq #(.WORD_W(WORD_W), .PTR_W(PTR_W), .OP_W(OP_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .head_i       (head_i),
        .issue_o      (issue),
        .we_o         (acc_we),
        .addr_o       (acc_addr),
        .wdata_o      (acc_wdata),
        .mem_done_i   (acc_done),
        .op_i         (dec_op),
        .last_i       (dec_last),
        .susp_i       (dec_susp),
        .intr_i       (dec_intr),
        .cap_o        (link_cap),
        .cap_sel_o    (link_sel),
        .link_i       (link_ptr),
        .link_end_i   (link_end),
        .exec_valid_o (exec_valid_o),
        .exec_op_o    (exec_op_o),
        .exec_blk_o   (exec_blk_o),
        .exec_done_i  (exec_done_i),
        .state_o      (unit_state_o),
        .irq_o        (irq_o),
        .cx_o         (cmd_cx_o)
    );

    cmdlist_mem_port #(.WORD_W(WORD_W), .PTR_W(PTR_W)) u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_i     (issue),
        .we_i        (acc_we),
        .addr_i      (acc_addr),
        .wdata_i     (acc_wdata),
        .done_o      (acc_done),
        .rdata_o     (acc_rdata),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_ack_i   (mem_ack_i),
        .mem_rdata_i (mem_rdata_i)
    );

    cmdlist_cmd_decode #(.WORD_W(WORD_W), .OP_W(OP_W)) u_dec (
        .word_i (acc_rdata),
        .op_o   (dec_op),
        .last_o (dec_last),
        .susp_o (dec_susp),
        .intr_o (dec_intr)
    );

    cmdlist_link_reg #(.WORD_W(WORD_W), .PTR_W(PTR_W)) u_link (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (link_cap),
        .sel_i  (link_sel),
        .word_i (acc_rdata),
        .ptr_o  (link_ptr),
        .end_o  (link_end)
    );

endmodule

// File: rtl/cmdlist_walker_chk.sv
// Module: protocol checker for the walker, bound to its top.
// What it does: watches the port-level rules for handshakes, state and interrupts.
// Assumes: it is attached through the bind below.
module cmdlist_walker_chk #(
    parameter int WORD_W = 16,
    parameter int OP_W   = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic                mem_req_o,
    input logic                mem_we_o,
    input logic [2*WORD_W-1:0] mem_addr_o,
    input logic [WORD_W-1:0]   mem_wdata_o,
    input logic                mem_ack_i,
    input logic                exec_valid_o,
    input logic [OP_W-1:0]     exec_op_o,
    input logic [2*WORD_W-1:0] exec_blk_o,
    input logic                exec_done_i,
    input logic [1:0]          unit_state_o,
    input logic                irq_o
);

    assert_legal_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        unit_state_o != 2'd3);

    assert_start_activates_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && unit_state_o != 2'd2) |=> unit_state_o == 2'd2);

    assert_exec_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid_o && !exec_done_i) |=>
            (exec_valid_o && $stable(exec_op_o) && $stable(exec_blk_o)));

    assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

    assert_one_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_o && exec_valid_o));

    assert_quiet_when_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_state_o != 2'd2) |-> (!mem_req_o && !exec_valid_o));

    assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

endmodule

bind cmdlist_walker cmdlist_walker_chk #(.WORD_W(WORD_W), .OP_W(OP_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_ack_i    (mem_ack_i),
    .exec_valid_o (exec_valid_o),
    .exec_op_o    (exec_op_o),
    .exec_blk_o   (exec_blk_o),
    .exec_done_i  (exec_done_i),
    .unit_state_o (unit_state_o),
    .irq_o        (irq_o)
);

// File: tb/tb_cmdlist_walker.sv
`timescale 1ns/1ps
// Bench: behavioural memory, executor and walk model; every access and
// handshake is compared against the model's expected stream.
module tb_cmdlist_walker;

    localparam int WORD_W = 16;
    localparam int OP_W   = 3;

    typedef struct {
        int          kind;   // 0 write, 1 read, 2 execute
        logic [31:0] addr;
        logic [15:0] data;   // write data or opcode
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [31:0] head_i;
    logic        mem_req_o;
    logic        mem_we_o;
    logic [31:0] mem_addr_o;
    logic [15:0] mem_wdata_o;
    logic        mem_ack_i;
    logic [15:0] mem_rdata_i;
    logic        exec_valid_o;
    logic [2:0]  exec_op_o;
    logic [31:0] exec_blk_o;
    logic        exec_done_i;
    logic [1:0]  unit_state_o;
    logic        irq_o;
    logic        cmd_cx_o;

    always #2 clk = ~clk;

    cmdlist_walker #(.WORD_W(WORD_W), .OP_W(OP_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .head_i(head_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
        .exec_valid_o(exec_valid_o), .exec_op_o(exec_op_o), .exec_blk_o(exec_blk_o),
        .exec_done_i(exec_done_i), .unit_state_o(unit_state_o), .irq_o(irq_o),
        .cmd_cx_o(cmd_cx_o)
    );

    logic [15:0] mem [int];
    item_t       exp_q [$];
    int          n_cmp = 0;
    int          n_bad = 0;
    int          irq_seen = 0;
    int          mem_dly = 0;
    int          exe_dly = 0;
    int          n_txn = 0;
    int          n_exe = 0;
    int          cycles = 0;
    bit          walking = 1'b0;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] rd(int a);
        return mem.exists(a) ? mem[a] : 16'h0000;
    endfunction

    task automatic put_blk(int a, logic [15:0] cmd, logic [31:0] link);
        mem[a]     = 16'h0000;
        mem[a + 2] = cmd;
        mem[a + 4] = link[15:0];
        mem[a + 6] = link[31:16];
    endtask

    // Walk model built from the requirements over the bench memory.
    task automatic build(int head, output int st, output bit cx, output int irqs);
        int a = head;
        cx   = cmd_cx_o;
        irqs = 0;
        st   = 0;
        for (int n = 0; n < 32; n++) begin
            logic [15:0] cmd;
            logic [31:0] link;
            cmd  = rd(a + 2);
            link = {rd(a + 6), rd(a + 4)};
            exp_q.push_back('{0, 32'(a), 16'h4000});
            exp_q.push_back('{1, 32'(a + 2), 16'h0});
            exp_q.push_back('{2, 32'(a), {13'h0, cmd[2:0]}});
            exp_q.push_back('{0, 32'(a), 16'hA000});
            exp_q.push_back('{1, 32'(a + 4), 16'h0});
            exp_q.push_back('{1, 32'(a + 6), 16'h0});
            cx = cmd[13];
            if (cmd[13]) irqs++;
            if (cmd[14]) begin st = 1; break; end
            if (cmd[15] || link == 32'h0 || link == 32'hFFFF_FFFF) begin st = 0; break; end
            a = int'(link);
        end
    endtask

    // Memory responder: variable wait, compares each access with the model (R3, R5).
    always @(negedge clk) begin
        bit prev;
        prev      = mem_ack_i;
        mem_ack_i = 1'b0;
        if (rst_n && mem_req_o && !prev) begin
            if (mem_dly > 0) begin
                mem_dly--;
            end else begin
                if (exp_q.size() == 0 || exp_q[0].kind == 2) begin
                    check(1'b0, "R3", "unexpected memory access", longint'(mem_addr_o), 0);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    check(e.kind == (mem_we_o ? 0 : 1), "R3", "access direction",
                          mem_we_o ? 0 : 1, e.kind);
                    check(mem_addr_o == e.addr, "R3", "access address", mem_addr_o, e.addr);
                    if (mem_we_o)
                        check(mem_wdata_o == e.data, "R3", "status word", mem_wdata_o, e.data);
                end
                mem_rdata_i = rd(int'(mem_addr_o));
                if (mem_we_o) mem[int'(mem_addr_o)] = mem_wdata_o;
                mem_ack_i = 1'b1;
                n_txn++;
                mem_dly = (n_txn * 3) % 5;
            end
        end
    end

    // Executor responder: compares opcode and block address (R4).
    always @(negedge clk) begin
        bit prev;
        prev        = exec_done_i;
        exec_done_i = 1'b0;
        if (rst_n && exec_valid_o && !prev) begin
            if (exe_dly > 0) begin
                exe_dly--;
            end else begin
                if (exp_q.size() == 0 || exp_q[0].kind != 2) begin
                    check(1'b0, "R4", "unexpected execute", longint'(exec_blk_o), 0);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    check(exec_op_o == e.data[2:0], "R4", "opcode", exec_op_o, e.data[2:0]);
                    check(exec_blk_o == e.addr, "R4", "block address", exec_blk_o, e.addr);
                end
                exec_done_i = 1'b1;
                n_exe++;
                exe_dly = n_exe % 3;
            end
        end
    end

    // Per-clock comparison of the unit state while the model still expects work (R2).
    always @(negedge clk) begin
        if (irq_o) irq_seen++;
        if (walking && exp_q.size() > 0)
            check(unit_state_o == 2'd2, "R2", "state during walk", unit_state_o, 2);
    end

    // Watchdog: a hung run is counted as a failure and still reaches the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            check(1'b0, "WATCHDOG", "run did not finish", cycles, 150000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic run_walk(int head, int extra, string req);
        int st;
        bit cx;
        int irqs;
        int g = 0;
        build(head, st, cx, irqs);
        irq_seen = 0;
        @(negedge clk);
        start_i = 1'b1;
        head_i  = 32'(head);
        @(negedge clk);
        start_i = 1'b0;
        walking = 1'b1;
        check(unit_state_o == 2'd2, "R2", "active after start", unit_state_o, 2);
        if (extra >= 0) begin
            repeat (5) @(negedge clk);
            start_i = 1'b1;            // R10: must be ignored
            head_i  = 32'(extra);
            @(negedge clk);
            start_i = 1'b0;
        end
        while (unit_state_o == 2'd2 && g < 5000) begin
            @(negedge clk);
            g++;
        end
        check(g < 5000, "WATCHDOG", "walk did not end", g, 5000);
        walking = 1'b0;
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, req, "accesses left unissued", exp_q.size(), 0);
        check(unit_state_o == 2'(st), req, "final state", unit_state_o, st);
        check(cmd_cx_o == cx, "R9", "complete status bit", cmd_cx_o, cx);
        check(irq_seen == irqs, "R9", "interrupt pulses", irq_seen, irqs);
        check(!mem_req_o && !exec_valid_o, req, "quiet after walk",
              {mem_req_o, exec_valid_o}, 0);
        exp_q.delete();
    endtask

    initial begin
        rst_n       = 1'b0;
        start_i     = 1'b0;
        head_i      = '0;
        mem_ack_i   = 1'b0;
        mem_rdata_i = '0;
        exec_done_i = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        check(unit_state_o == 2'd0, "R1", "state after reset", unit_state_o, 0);
        check(!mem_req_o, "R1", "mem_req after reset", mem_req_o, 0);
        check(!exec_valid_o, "R1", "exec_valid after reset", exec_valid_o, 0);
        check(!irq_o && !cmd_cx_o, "R1", "irq/cx after reset", {irq_o, cmd_cx_o}, 0);

        // R7: stop flag ends the walk although the link is a real address
        put_blk(32'h0100, 16'h8000, 32'h0000_0200);
        put_blk(32'h0200, 16'h0004, 32'h0000_0000);
        run_walk(32'h0100, -1, "R7");

        // R4/R6/R10: eight blocks, every opcode, zero link at the end, stray start
        for (int i = 0; i < 8; i++) begin
            logic [15:0] c;
            c = 16'(i);
            if (i == 2 || i == 7) c[13] = 1'b1;
            put_blk(32'h1000 + i * 16, c, (i == 7) ? 32'h0 : 32'(32'h1000 + (i + 1) * 16));
        end
        run_walk(32'h1000, 32'h0100, "R10");

        // R8: suspend in the middle, then resume ending on the all-ones link (R6)
        put_blk(32'h3000, 16'h0004, 32'h0000_3010);
        put_blk(32'h3010, 16'h4001, 32'h0000_3020);
        put_blk(32'h3020, 16'h2005, 32'hFFFF_FFFF);
        run_walk(32'h3000, -1, "R8");
        run_walk(32'h3020, -1, "R6");

        // R9: interrupt on the first block, cleared by the last one (stop flag, R7)
        put_blk(32'h4000, 16'h2002, 32'h0000_4010);
        put_blk(32'h4010, 16'h8003, 32'h0000_4020);
        run_walk(32'h4000, -1, "R9");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule